// File: doc/BRIEF.md
# SMBus Register Bridge

This block sits behind an SMBus slave byte engine. The engine handles bit timing and the packet error code. The bridge takes the bytes of each write transaction, checks the framing, and turns a complete frame into one access. A register frame becomes a 32-bit access on a simple internal register bus. Bytes whose lane enable is clear are preserved by a read-modify-write. An EEPROM frame becomes a single-byte request to an external serial EEPROM engine.

Read results are never returned inside the write transaction. A register read or EEPROM read is set up by a block write. A later block read fetches a fixed six-byte response:

- a length byte
- a status byte
- four data bytes

The bridge keeps exactly one internal access outstanding. A sticky error flag reports malformed frames, and commands that arrive while the bridge is busy, until the host reads the status byte.

Top module: `smb_reg_bridge`

## Requirements
- R1: A write frame is the command code, then a count byte, then a command byte, then the payload. Code 0x00 selects a register access and code 0x01 an EEPROM access. Any other code sets the error flag and issues no access.
- R2: In the command byte, bits 3:0 enable the data lanes (bit 0 for data[7:0] up to bit 3 for data[31:24]) and bit 4 is 1 for a write and 0 for a read. A register write has count 7: command, address[7:0], address[13:8] in bits 5:0, then data bytes least significant first. Its 14-bit doubleword address is presented unchanged on the bus. No access is issued before the frame's stop.
- R3: In a register write, a lane whose enable is clear keeps its old value. Four set enables give one bus write and no read. A partial set gives a read then a write to the same address. No set enables give no bus access.
- R4: A register read frame has count 3 (command, address low, address high). It reads the doubleword, and that word is returned by a later block read.
- R5: The block-read response is the value 5, then status (bit 0 error, bit 1 busy), then the four data bytes least significant first. Taking the status byte clears the error flag.
- R6: An EEPROM write frame has count 5: command, device address, byte address low, byte address high, data. It produces one EEPROM write request carrying those fields.
- R7: An EEPROM read frame has count 4 (command, device, address low, address high). The returned byte appears in data byte 0 of the response, and the upper three data bytes read zero.
- R8: If the count byte differs from the count the command requires, or the number of bytes after the count byte differs from the count, the error flag is set. The flag stays set, and no access is issued.
- R9: Only one internal access is outstanding at a time. A request is held with stable fields until acknowledged. A valid frame completing while an access is pending sets the error flag and is dropped.
- R10: A frame holding only the command code (the write phase of a block read) issues nothing and sets no error.
- R11: After reset no request is active, and the response reads 5, status 0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Pulse: a write transaction starts |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_stop | input | 1 | Pulse: the write transaction ended |
| tx_start | input | 1 | Pulse: a block read starts, response pointer to byte 0 |
| tx_next | input | 1 | Current response byte taken, advance pointer |
| tx_byte | output | 8 | Response byte at the pointer |
| reg_valid | output | 1 | Register request pending |
| reg_write | output | 1 | Request is a write |
| reg_addr | output | 14 | Doubleword address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Register request accepted |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| ee_valid | output | 1 | EEPROM request pending |
| ee_write | output | 1 | EEPROM request is a write |
| ee_dev | output | 8 | EEPROM device address |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM request finished |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |

## Verification
A corrupted frame index or a wrong count comparison is visible within a few cycles of the stop. It shows either as a bus request that should not occur or as a status byte whose error bit disagrees with the frame. A fault in the lane merge only appears after a later block read, as a word where preserved bytes were overwritten. Each table entry therefore pairs its write with a read-back, and counts bus reads and writes. A stuck busy state shows at once in the status bit and in later frames being flagged as errors.

// File: rtl/smb_bridge_pkg.sv
package smb_bridge_pkg;
    localparam int ADW      = 14;
    localparam int LANES    = 4;
    localparam int DW       = LANES * 8;
    localparam int PAYLOAD  = 2 + LANES;
    localparam int IDX_W    = 4;
    localparam logic [7:0] CODE_REG = 8'h00;
    localparam logic [7:0] CODE_EE  = 8'h01;
    localparam logic [7:0] CNT_RWR  = 8'd3 + 8'(LANES);
    localparam logic [7:0] CNT_RRD  = 8'd3;
    localparam logic [7:0] CNT_EWR  = 8'd5;
    localparam logic [7:0] CNT_ERD  = 8'd4;
    localparam logic [7:0] RSP_LEN  = 8'(LANES + 1);

    typedef struct packed {
        logic             is_ee;
        logic             wr;
        logic [LANES-1:0] be;
        logic [ADW-1:0]   addr;
        logic [DW-1:0]    wdata;
        logic [7:0]       dev;
        logic [15:0]      eaddr;
        logic [7:0]       edata;
    } op_t;

    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_EE} seq_st_t;
endpackage

// File: rtl/smb_frame_rx.sv
module smb_frame_rx
    import smb_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_stop,
    output logic       go,
    output logic       bad,
    output op_t        op
);
    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic [7:0]                code;
        logic [7:0]                cnt;
        logic [7:0]                cmd;
        logic [PAYLOAD-1:0][7:0]   pay;
        logic                      go;
        logic                      bad;
        op_t                       op;
    } rx_t;

    rx_t s_d, s_q;
    logic [IDX_W-1:0] k;
    logic [7:0]       exp_cnt;
    logic [7:0]       nrx;
    logic             code_ok;

    always_comb begin
        s_d     = s_q;
        s_d.go  = 1'b0;
        s_d.bad = 1'b0;
        k       = s_q.idx - IDX_W'(3);
        code_ok = (s_q.code == CODE_REG) || (s_q.code == CODE_EE);
        if (s_q.code == CODE_EE) exp_cnt = s_q.cmd[4] ? CNT_EWR : CNT_ERD;
        else                     exp_cnt = s_q.cmd[4] ? CNT_RWR : CNT_RRD;
        nrx     = 8'(s_q.idx) - 8'd2;
        if (rx_start) begin
            s_d.idx = '0;
        end else if (rx_valid) begin
            case (s_q.idx)
                IDX_W'(0): s_d.code = rx_byte;
                IDX_W'(1): s_d.cnt  = rx_byte;
                IDX_W'(2): s_d.cmd  = rx_byte;
                default: if (k < IDX_W'(PAYLOAD)) s_d.pay[k[2:0]] = rx_byte;
            endcase
            if (s_q.idx != '1) s_d.idx = s_q.idx + 1'b1;
        end else if (rx_stop) begin
            s_d.idx = '0;
            if (s_q.idx >= IDX_W'(2)) begin
                if (code_ok && (s_q.cnt == exp_cnt) && (nrx == s_q.cnt)) begin
                    s_d.go = 1'b1;
                end else begin
                    s_d.bad = 1'b1;
                end
                s_d.op.is_ee = (s_q.code == CODE_EE);
                s_d.op.wr    = s_q.cmd[4];
                s_d.op.be    = s_q.cmd[LANES-1:0];
                s_d.op.addr  = {s_q.pay[1][ADW-9:0], s_q.pay[0]};
                for (int i = 0; i < LANES; i++) begin
                    s_d.op.wdata[8*i +: 8] = s_q.pay[2+i];
                end
                s_d.op.dev   = s_q.pay[0];
                s_d.op.eaddr = {s_q.pay[2], s_q.pay[1]};
                s_d.op.edata = s_q.pay[3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign go  = s_q.go;
    assign bad = s_q.bad;
    assign op  = s_q.op;

    AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go || bad) |=> !(go || bad)) else $error("frame result repeated"); // R8
endmodule

// File: rtl/smb_acc_seq.sv
module smb_acc_seq
    import smb_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             bad,
    input  op_t              op_in,
    input  logic             clr,
    output logic             err,
    output logic             busy,
    output logic [DW-1:0]    rsp_data,
    output logic             reg_valid,
    output logic             reg_write,
    output logic [ADW-1:0]   reg_addr,
    output logic [DW-1:0]    reg_wdata,
    input  logic             reg_ack,
    input  logic [DW-1:0]    reg_rdata,
    output logic             ee_valid,
    output logic             ee_write,
    output logic [7:0]       ee_dev,
    output logic [15:0]      ee_addr,
    output logic [7:0]       ee_wdata,
    input  logic             ee_ack,
    input  logic [7:0]       ee_rdata
);
    typedef struct packed {
        seq_st_t       st;
        op_t           op;
        logic [DW-1:0] wdata;
        logic [DW-1:0] data;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;
    logic [DW-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = s_q.op.be[g] ? s_q.op.wdata[8*g +: 8]
                                               : reg_rdata[8*g +: 8];
    end

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            S_IDLE: if (go) begin
                s_d.op = op_in;
                if (op_in.is_ee) begin
                    s_d.st = S_EE;
                end else if (!op_in.wr) begin
                    s_d.st = S_RD;
                end else if (op_in.be == '1) begin
                    s_d.wdata = op_in.wdata;
                    s_d.st    = S_WR;
                end else if (op_in.be != '0) begin
                    s_d.st = S_RD;
                end
            end
            S_RD: if (reg_ack) begin
                if (s_q.op.wr) begin
                    s_d.wdata = merged;
                    s_d.st    = S_WR;
                end else begin
                    s_d.data = reg_rdata;
                    s_d.st   = S_IDLE;
                end
            end
            S_WR: if (reg_ack) s_d.st = S_IDLE;
            S_EE: if (ee_ack) begin
                if (!s_q.op.wr) s_d.data = {{(DW-8){1'b0}}, ee_rdata};
                s_d.st = S_IDLE;
            end
            default: s_d.st = S_IDLE;
        endcase
        if (clr) s_d.err = 1'b0;
        if (bad || (go && (s_q.st != S_IDLE))) s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err       = s_q.err;
    assign busy      = (s_q.st != S_IDLE);
    assign rsp_data  = s_q.data;
    assign reg_valid = (s_q.st == S_RD) || (s_q.st == S_WR);
    assign reg_write = (s_q.st == S_WR);
    assign reg_addr  = s_q.op.addr;
    assign reg_wdata = s_q.wdata;
    assign ee_valid  = (s_q.st == S_EE);
    assign ee_write  = s_q.op.wr;
    assign ee_dev    = s_q.op.dev;
    assign ee_addr   = s_q.op.eaddr;
    assign ee_wdata  = s_q.op.edata;

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_ack) |=> (reg_valid && $stable(reg_write) && $stable(reg_addr) && $stable(reg_wdata)))
        else $error("register request dropped early"); // R9
    AST_EE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_valid && !ee_ack) |=> (ee_valid && $stable(ee_write) && $stable(ee_addr) && $stable(ee_wdata)))
        else $error("eeprom request dropped early"); // R9
    AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && $past(reg_valid && !reg_write && reg_ack)) |-> (reg_addr == $past(reg_addr)))
        else $error("merge write moved address"); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err) else $error("error flag lost"); // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !bad && !(go && busy)) |=> !err) else $error("error flag not cleared"); // R5
endmodule

// File: rtl/smb_rsp_tx.sv
module smb_rsp_tx
    import smb_bridge_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_start,
    input  logic          tx_next,
    input  logic          err,
    input  logic          busy,
    input  logic [DW-1:0] data,
    output logic [7:0]    tx_byte,
    output logic          clr
);
    localparam int PW = $clog2(LANES + 3);

    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (tx_start)                        ptr_d = '0;
        else if (tx_next && (ptr_q != '1))   ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        tx_byte = 8'h00;
        if (ptr_q == PW'(0))      tx_byte = RSP_LEN;
        else if (ptr_q == PW'(1)) tx_byte = {6'b0, busy, err};
        else begin
            for (int i = 0; i < LANES; i++) begin
                if (ptr_q == PW'(i + 2)) tx_byte = data[8*i +: 8];
            end
        end
    end

    assign clr = tx_next && !tx_start && (ptr_q == PW'(1));
endmodule

// File: rtl/smb_reg_bridge.sv
module smb_reg_bridge
    import smb_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_start,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_stop,
    input  logic        tx_start,
    input  logic        tx_next,
    output logic [7:0]  tx_byte,
    output logic        reg_valid,
    output logic        reg_write,
    output logic [13:0] reg_addr,
    output logic [31:0] reg_wdata,
    input  logic        reg_ack,
    input  logic [31:0] reg_rdata,
    output logic        ee_valid,
    output logic        ee_write,
    output logic [7:0]  ee_dev,
    output logic [15:0] ee_addr,
    output logic [7:0]  ee_wdata,
    input  logic        ee_ack,
    input  logic [7:0]  ee_rdata
);
    logic          go, bad, clr, err, busy;
    op_t           op;
    logic [DW-1:0] rsp_data;

    smb_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_stop(rx_stop), .go(go), .bad(bad), .op(op)
    );

    smb_acc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .bad(bad), .op_in(op), .clr(clr),
        .err(err), .busy(busy), .rsp_data(rsp_data),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .ee_valid(ee_valid), .ee_write(ee_write), .ee_dev(ee_dev),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata)
    );

    smb_rsp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_next(tx_next),
        .err(err), .busy(busy), .data(rsp_data), .tx_byte(tx_byte), .clr(clr)
    );

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && ee_valid)) else $error("two requests at once"); // R9
endmodule

// File: tb/sim_smb_reg_bridge.sv
module sim_smb_reg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 0, rx_valid = 0, rx_stop = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_start = 0, tx_next = 0;
    logic [7:0]  tx_byte;
    logic        reg_valid, reg_write, reg_ack;
    logic [13:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        ee_valid, ee_write, ee_ack;
    logic [7:0]  ee_dev, ee_wdata, ee_rdata;
    logic [15:0] ee_addr;

    int errors = 0, checks = 0;
    int rd_ops, wr_ops, ee_ops, rw_wait, ee_wait;
    int ee_dly = 2;
    logic [31:0] mem [16];
    logic [13:0] last_addr;
    logic        ee_last_wr;
    logic [7:0]  ee_last_dev, ee_last_data;
    logic [15:0] ee_last_addr;

    always #4 clk = ~clk;

    smb_reg_bridge u0 (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'h1111_1111 * i;
            reg_ack <= 0; reg_rdata <= 0; ee_ack <= 0; ee_rdata <= 0;
            rd_ops <= 0; wr_ops <= 0; ee_ops <= 0; rw_wait <= 0; ee_wait <= 0;
            last_addr <= 0; ee_last_wr <= 0; ee_last_dev <= 0; ee_last_addr <= 0; ee_last_data <= 0;
        end else begin
            if (reg_ack) begin
                reg_ack <= 0; rw_wait <= 0; last_addr <= reg_addr;
                if (reg_write) begin mem[reg_addr[3:0]] <= reg_wdata; wr_ops <= wr_ops + 1; end
                else rd_ops <= rd_ops + 1;
            end else if (reg_valid) begin
                if (rw_wait >= 2) begin reg_ack <= 1; reg_rdata <= mem[reg_addr[3:0]]; end
                else rw_wait <= rw_wait + 1;
            end
            if (ee_ack) begin
                ee_ack <= 0; ee_wait <= 0; ee_ops <= ee_ops + 1;
                ee_last_wr <= ee_write; ee_last_dev <= ee_dev;
                ee_last_addr <= ee_addr; ee_last_data <= ee_wdata;
            end else if (ee_valid) begin
                if (ee_wait >= ee_dly) begin ee_ack <= 1; ee_rdata <= 8'hC3; end
                else ee_wait <= ee_wait + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [79:0] f, input int n, input int wt);
        @(negedge clk) rx_start = 1;
        @(negedge clk) rx_start = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = f[8*i +: 8];
            @(negedge clk);
        end
        rx_valid = 0; rx_stop = 1;
        @(negedge clk) rx_stop = 0;
        repeat (wt) @(negedge clk);
    endtask

    task automatic fetch(output logic [7:0] len, output logic [7:0] st, output logic [31:0] d);
        @(negedge clk) tx_start = 1;
        @(negedge clk) tx_start = 0;
        len = tx_byte; tx_next = 1;
        @(negedge clk) st = tx_byte;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) d[8*i +: 8] = tx_byte;
        end
        tx_next = 0;
    endtask

    function automatic logic [79:0] fr_wr(input logic [13:0] a, input logic [3:0] be, input logic [31:0] d);
        return {8'h0, d, 2'b0, a[13:8], a[7:0], 4'h1, be, 8'd7, 8'h00};
    endfunction
    function automatic logic [79:0] fr_rd(input logic [13:0] a);
        return {40'h0, 2'b0, a[13:8], a[7:0], 8'h0F, 8'd3, 8'h00};
    endfunction

    // addr, lane enables, write data, expected word afterwards, expected reads, expected writes
    localparam logic [89:0] TBL [6] = '{
        {14'h0003, 4'hF, 32'hDEADBEEF, 32'hDEADBEEF, 4'd0, 4'd1},
        {14'h2A03, 4'h1, 32'h000000AA, 32'hDEADBEAA, 4'd1, 4'd1},
        {14'h0105, 4'h6, 32'h12345678, 32'h55345655, 4'd1, 4'd1},
        {14'h0105, 4'h0, 32'hFFFFFFFF, 32'h55345655, 4'd0, 4'd0},
        {14'h3F07, 4'h8, 32'h9A000000, 32'h9A777777, 4'd1, 4'd1},
        {14'h1002, 4'hA, 32'h11223344, 32'h11223322, 4'd1, 4'd1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] len, st;
        logic [31:0] d;
        int r0, w0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 reg_valid", {31'b0, reg_valid}, 0);
        check("R11 ee_valid", {31'b0, ee_valid}, 0);
        fetch(len, st, d);
        check("R11 len", {24'b0, len}, 5);
        check("R11 status", {24'b0, st}, 0);
        check("R11 data", d, 0);

        // R2 R3 R4 R5 table walk
        foreach (TBL[i]) begin
            r0 = rd_ops; w0 = wr_ops;
            send(fr_wr(TBL[i][89:76], TBL[i][75:72], TBL[i][71:40]), 9, 20);
            check("R3 read count", rd_ops - r0, {28'b0, TBL[i][7:4]});
            check("R3 write count", wr_ops - w0, {28'b0, TBL[i][3:0]});
            check("R2 bus address", {18'b0, last_addr}, {18'b0, TBL[i][89:76]});
            send(fr_rd(TBL[i][89:76]), 5, 20);
            fetch(len, st, d);
            check("R5 length", {24'b0, len}, 5);
            check("R4 read data", d, TBL[i][39:8]);
        end

        // R10 code-only frame
        r0 = rd_ops; w0 = wr_ops;
        send(80'h00, 1, 10);
        check("R10 no access", (rd_ops - r0) + (wr_ops - w0), 0);
        fetch(len, st, d);
        check("R10 no error", {24'b0, st}, 0);

        // R1 unknown code
        send({8'h0, 32'h0, 8'h00, 8'h09, 8'h1F, 8'd7, 8'h07}, 9, 20);
        check("R1 no access", (rd_ops - r0) + (wr_ops - w0), 0);
        fetch(len, st, d);
        check("R1 error set", {24'b0, st}, 1);
        fetch(len, st, d);
        check("R5 error cleared by status read", {24'b0, st}, 0);

        // R8 too few bytes for count 7
        send(fr_wr(14'h0003, 4'hF, 32'h00000000), 8, 20);
        send(fr_rd(14'h0003), 5, 20);
        fetch(len, st, d);
        check("R8 short frame error", {24'b0, st}, 1);
        check("R8 short frame dropped", d, 32'hDEADBEAA);
        // R8 count byte inconsistent with command
        w0 = wr_ops;
        send({16'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h1F, 8'd6, 8'h00}, 8, 20);
        check("R8 count mismatch no write", wr_ops - w0, 0);
        fetch(len, st, d);
        check("R8 count mismatch error", {24'b0, st}, 1);

        // R6 eeprom write
        e0 = ee_ops;
        send({16'h0, 8'h5A, 8'h12, 8'h34, 8'hA0, 8'h10, 8'd5, 8'h01}, 7, 15);
        check("R6 one request", ee_ops - e0, 1);
        check("R6 write flag", {31'b0, ee_last_wr}, 1);
        check("R6 device", {24'b0, ee_last_dev}, 32'hA0);
        check("R6 address", {16'b0, ee_last_addr}, 32'h1234);
        check("R6 data", {24'b0, ee_last_data}, 32'h5A);

        // R7 eeprom read
        send({32'h0, 8'h56, 8'h78, 8'hA2, 8'h00, 8'd4, 8'h01}, 6, 15);
        check("R7 read flag", {31'b0, ee_last_wr}, 0);
        check("R7 address", {16'b0, ee_last_addr}, 32'h5678);
        fetch(len, st, d);
        check("R7 returned byte", d, 32'h000000C3);

        // R9 command while busy
        ee_dly = 40; e0 = ee_ops; w0 = wr_ops;
        send({16'h0, 8'h77, 8'h00, 8'h01, 8'hA0, 8'h10, 8'd5, 8'h01}, 7, 2);
        fetch(len, st, d);
        check("R9 busy bit", {24'b0, st}, 2);
        send(fr_wr(14'h0009, 4'hF, 32'h0), 9, 60);
        check("R9 dropped write", wr_ops - w0, 0);
        check("R9 first request done", ee_ops - e0, 1);
        fetch(len, st, d);
        check("R9 error, idle", {24'b0, st}, 1);
        send(fr_rd(14'h0009), 5, 20);
        fetch(len, st, d);
        check("R9 register untouched", d, 32'h99999999);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule